// File: doc/BRIEF.md
# Banked Video Filter Parameter Store

This block keeps the system-dependent settings of a video comb filter in five independent banks, one per broadcast standard. Bank 0 serves PAL B/G/H/I/D/K, bank 1 PAL M, bank 2 PAL N and bank 3 NTSC. Bank 4 is the bypass bank. A host reaches the store through a plain register port with an address, write data, a write strobe and combinational read data. That port normally sits behind a serial control slave.

An eight-bit select register holds two independent bank pointers. The low pointer picks the bank that host parameter writes land in and that reads return. The high pointer picks the bank that drives the filter. Every host write lands in shadow storage. On a single-cycle vertical-sync strobe, all shadow words and the high pointer move together into live storage. The filter therefore never sees its settings change in the middle of a field. The outputs are the parameter words of the live active bank and a bypass flag.

Top module: `bank_param_regs`

## Requirements
- R1: When reset is asserted, every shadow and live word clears to zero and the select register reads 0x44. As a result, `bypass` is 1 and `param_out` is 0.
- R2: Address 0 is the select register. It stores bits [7:0] exactly as written and reads them back with upper data bits 0. Addresses 1..NWORDS map word `addr-1` of the write bank, and reads of those addresses return its shadow value. All other addresses read 0 and ignore writes.
- R3: A parameter write with a write-bank pointer (select bits [2:0]) of 0..4 changes the shadow word of that bank only. The write does not appear on `param_out` before the next sync strobe.
- R4: When the write-bank pointer is 5..7, parameter writes are ignored and parameter reads return 0.
- R5: On a cycle with `vsync` high, every bank's shadow words are copied to its live words. In the same edge, the live active pointer takes select bits [6:4]. The outputs show the new values right after that edge.
- R6: A change of the active pointer in the select register has no effect on `param_out` or `bypass` until the next sync strobe.
- R7: `bypass` is 1 exactly when the live active pointer is 4 or an invalid value 5..7. An invalid pointer drives the live words of bank 4.
- R8: When a write and `vsync` fall in the same cycle, the transfer uses the values from before the write. The written parameter or pointer reaches the outputs at the following strobe.
- R9: `param_out` carries live word w of the active bank at bits [w*DW +: DW]. The banks do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Single-cycle field boundary strobe, shadow-to-live transfer |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | DW | Combinational read data |
| param_out | output | NWORDS*DW | Live parameter words of the active bank |
| bypass | output | 1 | Filter pass-through request |

## Verification
A host write and the sync strobe can land on the same clock edge. The ordering there decides whether a field runs with half-updated settings. The bench drives a parameter write together with `vsync` in one cycle, and then a select write together with `vsync`. It expects the outputs to keep the pre-write word or bank after that edge. It then expects the new value to appear only after one further strobe.

// File: rtl/bank_param_regs.sv
module bank_param_regs #(
  parameter int DW     = 16,
  parameter int NWORDS = 4,
  parameter int AW     = 3,
  parameter int NBANK  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  input  logic                 reg_wr,
  output logic [DW-1:0]        reg_rdata,
  output logic [NWORDS*DW-1:0] param_out,
  output logic                 bypass
);
  localparam logic [2:0] BYP_BANK = 3'(NBANK - 1);
  localparam logic [7:0] SEL_RST  = {1'b0, BYP_BANK, 1'b0, BYP_BANK};

  logic [DW-1:0] shadow_q [NBANK][NWORDS];
  logic [DW-1:0] live_q   [NBANK][NWORDS];
  logic [7:0]    sel_q;
  logic [2:0]    act_q;
  logic [NBANK*NWORDS*DW-1:0] shadow_flat;

  logic [2:0]    wbank, eff;
  logic          wvalid, sel_hit, prm_hit;
  logic [AW-1:0] widx;

  assign wbank   = sel_q[2:0];
  assign wvalid  = wbank < 3'(NBANK);
  assign sel_hit = reg_addr == '0;
  assign prm_hit = !sel_hit && (32'(reg_addr) <= NWORDS);
  assign widx    = reg_addr - AW'(1);
  assign eff     = (act_q < 3'(NBANK)) ? act_q : BYP_BANK;
  assign bypass  = eff == BYP_BANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
    end else if (reg_wr && sel_hit) begin
      sel_q <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= BYP_BANK;
    end else if (vsync) begin
      act_q <= sel_q[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < NWORDS; w++)
          shadow_q[b][w] <= '0;
    end else if (reg_wr && prm_hit && wvalid) begin
      shadow_q[wbank][widx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < NWORDS; w++)
          live_q[b][w] <= '0;
    end else if (vsync) begin
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < NWORDS; w++)
          live_q[b][w] <= shadow_q[b][w];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_hit)
      reg_rdata = DW'(sel_q);
    else if (prm_hit && wvalid)
      reg_rdata = shadow_q[wbank][widx];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_out
    assign param_out[w*DW +: DW] = live_q[eff][w];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_flat_b
    for (genvar w = 0; w < NWORDS; w++) begin : g_flat_w
      assign shadow_flat[(b*NWORDS+w)*DW +: DW] = shadow_q[b][w];
    end
  end
endmodule

// File: rtl/bank_param_regs_chk.sv
module bank_param_regs_chk #(
  parameter int DW     = 16,
  parameter int NWORDS = 4,
  parameter int AW     = 3,
  parameter int NBANK  = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       vsync,
  input logic                       reg_wr,
  input logic [AW-1:0]              reg_addr,
  input logic [DW-1:0]              reg_wdata,
  input logic [7:0]                 sel_q,
  input logic [NBANK*NWORDS*DW-1:0] shadow_flat,
  input logic [NWORDS*DW-1:0]       param_out,
  input logic                       bypass
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(param_out)); // R5
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(bypass)); // R6
  AST_BYP_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (bypass == ($past(sel_q[6:4]) >= 3'(NBANK - 1)))); // R7
  AST_SEL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0) |=> (sel_q == $past(reg_wdata[7:0]))); // R2
  AST_BAD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_q[2:0] >= 3'(NBANK)) |=> $stable(shadow_flat)); // R4
endmodule

bind bank_param_regs bank_param_regs_chk #(
  .DW(DW), .NWORDS(NWORDS), .AW(AW), .NBANK(NBANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sel_q(sel_q),
  .shadow_flat(shadow_flat), .param_out(param_out), .bypass(bypass)
);

// File: tb/sim_bank_param_regs.sv
`timescale 1ns/1ps
module sim_bank_param_regs;
  localparam int DW = 16, NWORDS = 4, AW = 3, NBANK = 5;
  localparam int NV = 17;
  // {op(1: sync, 0: write), addr[2:0], data[15:0], chk, exp_word0[15:0], exp_byp}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 3'd0, 16'h0040, 1'b1, 16'h0000, 1'b1},
    {1'b0, 3'd1, 16'h1111, 1'b1, 16'h0000, 1'b1},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h0000, 1'b1},
    {1'b0, 3'd0, 16'h0001, 1'b1, 16'h0000, 1'b1},
    {1'b0, 3'd1, 16'h2222, 1'b1, 16'h0000, 1'b1},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h1111, 1'b0},
    {1'b0, 3'd0, 16'h0013, 1'b1, 16'h1111, 1'b0},
    {1'b0, 3'd1, 16'h3333, 1'b1, 16'h1111, 1'b0},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h2222, 1'b0},
    {1'b0, 3'd0, 16'h0034, 1'b1, 16'h2222, 1'b0},
    {1'b0, 3'd1, 16'h4444, 1'b1, 16'h2222, 1'b0},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h3333, 1'b0},
    {1'b0, 3'd0, 16'h0045, 1'b1, 16'h3333, 1'b0},
    {1'b0, 3'd1, 16'h5555, 1'b1, 16'h3333, 1'b0},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h4444, 1'b1},
    {1'b0, 3'd0, 16'h0070, 1'b1, 16'h4444, 1'b1},
    {1'b1, 3'd0, 16'h0000, 1'b1, 16'h4444, 1'b1}
  };

  logic clk = 0, rst_n = 0, vsync = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [NWORDS*DW-1:0] param_out;
  logic bypass;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_param_regs #(.DW(DW), .NWORDS(NWORDS), .AW(AW), .NBANK(NBANK)) u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .param_out(param_out), .bypass(bypass));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit with_sync = 0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1; vsync = with_sync;
    @(negedge clk);
    reg_wr = 0; vsync = 0;
  endtask

  task automatic sync_pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req, logic [DW-1:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 bypass", 64'(bypass), 64'd1);
    check("R1 params", param_out, 64'd0);
    rd(3'd0, "R1 select", 16'h0044);
    rd(3'd1, "R1 shadow", 16'h0000);

    // table walk: R3 writes hidden until sync, R5 transfer, R6 pointer deferral, R7 bypass
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      if (v[37]) sync_pulse();
      else wr(v[36:34], v[33:18]);
      if (v[17]) begin
        check($sformatf("R3/R5/R6 word0 step %0d", i), 64'(param_out[15:0]), 64'(v[16:1]));
        check($sformatf("R7 bypass step %0d", i), 64'(bypass), 64'(v[0]));
      end
    end

    // R2 address map and readback
    wr(3'd0, 16'h0000);
    rd(3'd1, "R2 bank0 word0", 16'h1111);
    rd(3'd2, "R2 bank0 word1", 16'h0000);
    rd(3'd5, "R2 unmapped read", 16'h0000);
    wr(3'd7, 16'hFFFF);
    rd(3'd7, "R2 unmapped write", 16'h0000);
    wr(3'd0, 16'hFF8C);
    rd(3'd0, "R2 select echo", 16'h008C);

    // R4 invalid write bank
    wr(3'd0, 16'h0005);
    rd(3'd1, "R4 read invalid bank", 16'h0000);
    wr(3'd1, 16'h7777);
    wr(3'd0, 16'h0004);
    rd(3'd1, "R4 bank4 untouched", 16'h4444);
    wr(3'd0, 16'h0000);
    rd(3'd1, "R4 bank0 untouched", 16'h1111);
    check("R6 before sync", 64'(bypass), 64'd1);
    sync_pulse();
    check("R5 bank0 live", 64'(param_out[15:0]), 64'h1111);
    check("R7 bank0 no bypass", 64'(bypass), 64'd0);

    // R8 write and sync on one edge
    wr(3'd1, 16'hABCD, 1);
    check("R8 param old value kept", 64'(param_out[15:0]), 64'h1111);
    sync_pulse();
    check("R8 param next sync", 64'(param_out[15:0]), 64'hABCD);
    wr(3'd0, 16'h0030, 1);
    check("R8 pointer old bank kept", 64'(param_out[15:0]), 64'hABCD);
    sync_pulse();
    check("R8 pointer next sync", 64'(param_out[15:0]), 64'h3333);

    // R9 full word layout of one bank
    wr(3'd0, 16'h0022);
    for (int w = 1; w <= NWORDS; w++) wr(3'(w), 16'hB000 + 16'(w));
    sync_pulse();
    check("R9 bank2 words", param_out, 64'hB004_B003_B002_B001);
    wr(3'd0, 16'h0000);
    rd(3'd1, "R9 bank0 intact", 16'hABCD);

    // R1 reset mid-run
    do_reset();
    check("R1 mid bypass", 64'(bypass), 64'd1);
    check("R1 mid params", param_out, 64'd0);
    rd(3'd0, "R1 mid select", 16'h0044);
    wr(3'd0, 16'h0000);
    rd(3'd1, "R1 mid bank0", 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule